// File: doc/BRIEF.md
# Full-Rate Steady-State Kalman Demodulator

This block recovers a multi-bit signal estimate from the one-bit output of a second-order sigma-delta modulator. It is a recursive lowpass filter that runs at the bitstream rate. A fixed, precomputed steady-state gain vector stands in for a gain computed online. Each accepted bit updates a three-element state estimate through constant multipliers. The bit goes into the filter as it is, with no integrator in front. The differencing that this leaves out is made up at the output: the first state element passes through two cascaded running sums.

The full-rate estimate appears one cycle after every accepted bit. A second output keeps one estimate in every group of N accepted bits and holds it until the next group ends. All values are signed fixed point in 32-bit words, with 24 fraction bits. The arithmetic wraps modulo 2^32 instead of saturating.

Top module: `kdemod_top`

## Requirements
- R1: While `rst_n` is low, and until the first accepted bit after it is released, `est_valid` and `dec_valid` are 0 and `est_data` and `dec_data` are 0. Reset clears the state vector and both output sums.
- R2: `est_valid` is high in exactly the cycle after each cycle where `bit_valid` is high, and is low otherwise.
- R3: A cycle with `bit_valid` low leaves the state, the output sums, `est_data` and `dec_data` unchanged.
- R4: An accepted bit value 1 is taken as +1.0 (0x0100_0000) and value 0 as -1.0 (0xFF00_0000).
- R5: On an accepted bit p, the prediction is s1=g1, s2=g1+g2, s3=g1+g2+g3. The innovation is e=p-s3. Each new state element is gi'=si+((e*Ki)>>>24). The gains Ki are the Q0.24 constants 1007, 76672 and 1892470, and >>> is an arithmetic shift (rounding toward minus infinity).
- R6: On each accepted bit, the first sum gains the old g1 and the second sum gains the old first sum. `est_data` is the second sum.
- R7: Every addition, subtraction and product result is kept to 32 bits by two's-complement wrap.
- R8: `dec_valid` pulses for one cycle after every 128th accepted bit (the 128th, 256th, and so on, counted from reset). `dec_data` takes the value of `est_data` in that cycle and holds it until the next pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bit_valid | input | 1 | Qualifies `bit_in` for this cycle |
| bit_in | input | 1 | Modulator output bit |
| est_valid | output | 1 | Full-rate estimate strobe |
| est_data | output | 32 | Full-rate estimate, signed Q8.24 |
| dec_valid | output | 1 | Decimated estimate strobe |
| dec_data | output | 32 | Decimated estimate, signed Q8.24, held between strobes |

## Verification
A wrong gain, a wrong prediction sum or a wrong bit mapping corrupts g1. That error reaches `est_data` only after two accepted bits, through the two output sums. It then grows quickly, because both sums keep it. The bench runs a bit-exact model of the recursion and compares every output on every cycle, so any such fault shows within a few samples. Patterns of several bit densities are used, with idle gaps between samples. A fault in the decimation counter shows as a misplaced `dec_valid` at the end of the first group of 128 samples.

// File: rtl/kd_pkg.sv
package kd_pkg;
  // Default word geometry: signed Q8.24 datapath, Q0.24 gains.
  localparam int DATA_W = 32;
  localparam int FRAC_W = 24;
  localparam int GAIN_W = 25;

  // Steady-state gains in Q0.24 for an oversampling ratio of 128.
  localparam int GAIN_1 = 1007;
  localparam int GAIN_2 = 76672;
  localparam int GAIN_3 = 1892470;

  localparam int DEC_RATIO = 128;

  // Map a modulator bit onto +/-1.0 in the datapath format.
  function automatic logic signed [DATA_W-1:0] bit_to_fix(input logic b);
    logic signed [DATA_W-1:0] one;
    one = DATA_W'(1) <<< FRAC_W;
    return b ? one : -one;
  endfunction
endpackage

// File: rtl/kd_gain_lane.sv
// One state lane: predicted value plus the scaled innovation.
module kd_gain_lane #(
  parameter int DATA_W = 32,
  parameter int FRAC_W = 24,
  parameter int GAIN_W = 25,
  parameter int GAIN   = 0
) (
  input  logic signed [DATA_W-1:0] pred_i,
  input  logic signed [DATA_W-1:0] innov_i,
  output logic signed [DATA_W-1:0] next_o
);
  localparam int PROD_W = DATA_W + GAIN_W;
  localparam logic signed [PROD_W-1:0] GAIN_C = PROD_W'(GAIN);

  logic signed [PROD_W-1:0] innov_ext;

  always_comb begin
    innov_ext = PROD_W'(innov_i);
    next_o    = pred_i + DATA_W'((innov_ext * GAIN_C) >>> FRAC_W);
  end
endmodule

// File: rtl/kd_state_update.sv
// Three-element state, lower-triangular prediction and constant-gain correction.
module kd_state_update #(
  parameter int DATA_W = 32,
  parameter int FRAC_W = 24,
  parameter int GAIN_W = 25,
  parameter int GAIN_1 = 1007,
  parameter int GAIN_2 = 76672,
  parameter int GAIN_3 = 1892470
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ce,
  input  logic signed [DATA_W-1:0] obs_i,
  output logic signed [DATA_W-1:0] g1_o
);
  localparam int N_ST = 3;

  logic signed [DATA_W-1:0] st_q    [N_ST];
  logic signed [DATA_W-1:0] st_d    [N_ST];
  logic signed [DATA_W-1:0] pred    [N_ST];
  logic signed [DATA_W-1:0] corr    [N_ST];
  logic signed [DATA_W-1:0] innov;

  // Prediction: each element is the running sum of the elements above it.
  always_comb begin
    pred[0] = st_q[0];
    for (int i = 1; i < N_ST; i++) begin
      pred[i] = pred[i-1] + st_q[i];
    end
    innov = obs_i - pred[N_ST-1];
  end

  for (genvar gi = 0; gi < N_ST; gi++) begin : g_lane
    localparam int LANE_GAIN = (gi == 0) ? GAIN_1 : ((gi == 1) ? GAIN_2 : GAIN_3);
    kd_gain_lane #(
      .DATA_W (DATA_W),
      .FRAC_W (FRAC_W),
      .GAIN_W (GAIN_W),
      .GAIN   (LANE_GAIN)
    ) u_lane (
      .pred_i  (pred[gi]),
      .innov_i (innov),
      .next_o  (corr[gi])
    );
  end

  always_comb begin
    for (int i = 0; i < N_ST; i++) begin
      st_d[i] = ce ? corr[i] : st_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_ST; i++) st_q[i] <= '0;
    end else begin
      for (int i = 0; i < N_ST; i++) st_q[i] <= st_d[i];
    end
  end

  assign g1_o = st_q[0];
endmodule

// File: rtl/kd_out_integ.sv
// Two cascaded running sums restoring the differencing moved out of the input.
module kd_out_integ #(
  parameter int DATA_W = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ce,
  input  logic signed [DATA_W-1:0] g1_i,
  output logic signed [DATA_W-1:0] sum2_nxt_o,
  output logic signed [DATA_W-1:0] sum2_o,
  output logic                     vld_o
);
  logic signed [DATA_W-1:0] sum1_q, sum1_d;
  logic signed [DATA_W-1:0] sum2_q, sum2_d;
  logic                     vld_q;

  always_comb begin
    sum1_d = sum1_q;
    sum2_d = sum2_q;
    if (ce) begin
      sum1_d = sum1_q + g1_i;
      sum2_d = sum2_q + sum1_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum1_q <= '0;
      sum2_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      sum1_q <= sum1_d;
      sum2_q <= sum2_d;
      vld_q  <= ce;
    end
  end

  assign sum2_nxt_o = sum2_d;
  assign sum2_o     = sum2_q;
  assign vld_o      = vld_q;
endmodule

// File: rtl/kd_decim.sv
// Keeps one estimate out of every DEC_N accepted samples.
module kd_decim #(
  parameter int DATA_W = 32,
  parameter int DEC_N  = 128
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ce,
  input  logic signed [DATA_W-1:0] est_nxt_i,
  output logic                     dec_vld_o,
  output logic signed [DATA_W-1:0] dec_data_o
);
  localparam int CNT_W = (DEC_N > 1) ? $clog2(DEC_N) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DEC_N - 1);

  logic [CNT_W-1:0]         cnt_q, cnt_d;
  logic                     fire;
  logic signed [DATA_W-1:0] data_q, data_d;

  always_comb begin
    fire   = ce && (cnt_q == LAST);
    cnt_d  = cnt_q;
    data_d = data_q;
    if (ce) begin
      cnt_d = fire ? '0 : cnt_q + CNT_W'(1);
    end
    if (fire) begin
      data_d = est_nxt_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      data_q    <= '0;
      dec_vld_o <= 1'b0;
    end else begin
      cnt_q     <= cnt_d;
      data_q    <= data_d;
      dec_vld_o <= fire;
    end
  end

  assign dec_data_o = data_q;
endmodule

// File: rtl/kdemod_top.sv
module kdemod_top #(
  parameter int DATA_W = kd_pkg::DATA_W,
  parameter int FRAC_W = kd_pkg::FRAC_W,
  parameter int GAIN_W = kd_pkg::GAIN_W,
  parameter int GAIN_1 = kd_pkg::GAIN_1,
  parameter int GAIN_2 = kd_pkg::GAIN_2,
  parameter int GAIN_3 = kd_pkg::GAIN_3,
  parameter int DEC_N  = kd_pkg::DEC_RATIO
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_valid,
  input  logic              bit_in,
  output logic              est_valid,
  output logic [DATA_W-1:0] est_data,
  output logic              dec_valid,
  output logic [DATA_W-1:0] dec_data
);
  localparam logic signed [DATA_W-1:0] ONE_FIX = DATA_W'(1) <<< FRAC_W;

  // Reset asserts at once and is released after two clock edges.
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic                     ce;
  logic signed [DATA_W-1:0] obs;
  logic signed [DATA_W-1:0] g1;
  logic signed [DATA_W-1:0] sum2_nxt;
  logic signed [DATA_W-1:0] sum2;
  logic signed [DATA_W-1:0] dec_word;

  assign ce  = bit_valid;
  assign obs = bit_in ? ONE_FIX : -ONE_FIX;

  kd_state_update #(
    .DATA_W (DATA_W), .FRAC_W (FRAC_W), .GAIN_W (GAIN_W),
    .GAIN_1 (GAIN_1), .GAIN_2 (GAIN_2), .GAIN_3 (GAIN_3)
  ) u_state (
    .clk   (clk),
    .rst_n (rst_int_n),
    .ce    (ce),
    .obs_i (obs),
    .g1_o  (g1)
  );

  kd_out_integ #(.DATA_W (DATA_W)) u_integ (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .ce         (ce),
    .g1_i       (g1),
    .sum2_nxt_o (sum2_nxt),
    .sum2_o     (sum2),
    .vld_o      (est_valid)
  );

  kd_decim #(.DATA_W (DATA_W), .DEC_N (DEC_N)) u_decim (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .ce         (ce),
    .est_nxt_i  (sum2_nxt),
    .dec_vld_o  (dec_valid),
    .dec_data_o (dec_word)
  );

  assign est_data = sum2;
  assign dec_data = dec_word;
endmodule

// File: rtl/kdemod_chk.sv
module kdemod_chk #(
  parameter int DATA_W = 32,
  parameter int DEC_N  = 128
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bit_valid,
  input logic              est_valid,
  input logic [DATA_W-1:0] est_data,
  input logic              dec_valid,
  input logic [DATA_W-1:0] dec_data
);
  localparam int CW = $clog2(DEC_N) + 1;
  logic [CW-1:0] since_dec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         since_dec <= '0;
    else if (dec_valid) since_dec <= '0;
    else if (est_valid) since_dec <= since_dec + CW'(1);
  end

  // R2: every accepted bit yields a strobe in the next cycle
  a_r2_strobe_follows: assert property (@(posedge clk) disable iff (!rst_n)
    bit_valid |=> est_valid);
  // R2: no strobe without an accepted bit the cycle before
  a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_valid |=> !est_valid);
  // R3: idle cycles leave the estimate untouched
  a_r3_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_valid |=> $stable(est_data));
  // R8: decimated strobe only together with a full-rate strobe
  a_r8_dec_with_est: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> est_valid);
  // R8: decimated word equals the full-rate word when taken
  a_r8_dec_match: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> (dec_data == est_data));
  // R8: decimated word holds between strobes
  a_r8_dec_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_valid |-> $stable(dec_data));
  // R8: group spacing of DEC_N accepted samples
  a_r8_dec_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> (since_dec == CW'(DEC_N - 1)));
endmodule

bind kdemod_top kdemod_chk #(.DATA_W (DATA_W), .DEC_N (DEC_N)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bit_valid (bit_valid),
  .est_valid (est_valid),
  .est_data  (est_data),
  .dec_valid (dec_valid),
  .dec_data  (dec_data)
);

// File: tb/tb_kdemod_top.sv
`timescale 1ns/1ps
module tb_kdemod_top;
  logic        clk;
  logic        rst_n;
  logic        bit_valid;
  logic        bit_in;
  logic        est_valid;
  logic [31:0] est_data;
  logic        dec_valid;
  logic [31:0] dec_data;

  kdemod_top dut (
    .clk (clk), .rst_n (rst_n), .bit_valid (bit_valid), .bit_in (bit_in),
    .est_valid (est_valid), .est_data (est_data),
    .dec_valid (dec_valid), .dec_data (dec_data)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // Behavioural model state
  int  m_g1, m_g2, m_g3, m_s1, m_s2, m_cnt;
  int  x_est, x_dec;
  bit  x_ev, x_dv, prev_idle;
  int  n_vec, n_bad;
  bit  finished;

  function automatic int scale(input int e, input int k);
    longint p;
    p = longint'(e) * longint'(k);
    return int'(p >>> 24);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R2 est_valid", {31'd0, est_valid}, {31'd0, x_ev});
    chk(prev_idle ? "R3 est_data after idle" : "R4/R5/R6/R7 est_data", est_data, x_est);
    chk("R8 dec_valid", {31'd0, dec_valid}, {31'd0, x_dv});
    chk("R8 dec_data", dec_data, x_dec);
  endtask

  // One cycle: check the previous result, then drive and advance the model.
  task automatic step(input bit v, input bit b);
    int p, s1, s2, s3, e, og1, os1;
    @(negedge clk);
    compare_all();
    bit_valid = v;
    bit_in    = b;
    prev_idle = !v;
    x_ev = v;
    x_dv = 1'b0;
    if (v) begin
      p   = b ? 32'sh0100_0000 : -32'sh0100_0000;   // R4 mapping
      s1  = m_g1;
      s2  = m_g1 + m_g2;
      s3  = s2 + m_g3;
      e   = p - s3;
      og1 = m_g1;
      os1 = m_s1;
      m_g1 = s1 + scale(e, 1007);
      m_g2 = s2 + scale(e, 76672);
      m_g3 = s3 + scale(e, 1892470);
      m_s1 = m_s1 + og1;
      m_s2 = m_s2 + os1;
      x_est = m_s2;
      m_cnt++;
      if (m_cnt == 128) begin
        m_cnt = 0;
        x_dv  = 1'b1;
        x_dec = x_est;
      end
    end
  endtask

  task automatic run_pattern(input int ones, input int period, input int len, input int gap);
    for (int i = 0; i < len; i++) begin
      if (gap > 0 && (i % gap) == gap - 1) step(1'b0, 1'b1);
      step(1'b1, (i % period) < ones);
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    n_vec = 0; n_bad = 0; finished = 0;
    m_g1 = 0; m_g2 = 0; m_g3 = 0; m_s1 = 0; m_s2 = 0; m_cnt = 0;
    x_est = 0; x_dec = 0; x_ev = 0; x_dv = 0; prev_idle = 0;
    bit_valid = 1'b0; bit_in = 1'b0;
    rst_n = 1'b0;
    // R1: outputs cleared while reset is asserted, even with bits offered
    repeat (3) begin
      @(negedge clk);
      bit_valid = 1'b1;
      bit_in    = 1'b1;
      chk("R1 est_valid in reset", {31'd0, est_valid}, 32'd0);
      chk("R1 est_data in reset", est_data, 32'd0);
      chk("R1 dec_valid in reset", {31'd0, dec_valid}, 32'd0);
      chk("R1 dec_data in reset", dec_data, 32'd0);
    end
    @(negedge clk);
    bit_valid = 1'b0;
    rst_n = 1'b1;
    // Idle while the internal reset release completes (R1)
    repeat (4) step(1'b0, 1'b0);
    run_pattern(1, 2, 300, 0);     // density one half
    run_pattern(3, 4, 300, 7);     // three quarters, idle gaps (R3)
    run_pattern(1, 8, 300, 0);     // one eighth
    run_pattern(5, 8, 300, 5);     // five eighths with gaps
    run_pattern(1, 1, 200, 0);     // solid ones
    run_pattern(0, 1, 200, 0);     // solid zeros
    repeat (3) step(1'b0, 1'b0);
    @(negedge clk);
    compare_all();
    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule